// File: doc/BRIEF.md
# Coded Bitstream Bus Word Packer

This block sits between a bit-serial entropy coder and a host-side code-data bus. Coded bits arrive one per accepted cycle, in time order. The block gathers them into bytes and then into bus words of 8, 16 or 32 bits. The bit order inside each byte and the byte-lane order inside each word are set by configuration inputs. When a frame ends in the middle of a word, the block fills the rest with zeros, so the final word is complete and aligned.

Configuration is taken in only while the block holds no partial data. A configuration change that arrives in the middle of a word therefore cannot tear that word apart. A reserved width code is reported as an error. While that code is in force, incoming bits are consumed and dropped, and nothing is emitted. The output side uses a valid/ready handshake that can stall. The input side uses a valid/ready handshake with an end-of-frame marker that travels with the final bit.

Top module: `cbw_packer`

## Requirements
- R1: Width code 00 gives 8-bit words, 01 gives 16-bit words and 10 gives 32-bit words. A word is emitted after that many accepted bits. In the narrower modes, the output bits above the active width read as zero.
- R2: Width code 11 raises `cfg_err`. While it is in force, `in_ready` stays high, accepted bits are discarded and `out_valid` never rises. After a legal code is applied, the next frame starts from an empty word.
- R3: With `cfg_bit_lsb_first`=0, bit k (k = 0..7 in arrival order) of a byte lands on bit 7-k of its lane. With `cfg_bit_lsb_first`=1, it lands on bit k of its lane.
- R4: With `cfg_lane_high_first`=0, the n-th byte of a word occupies lane n, that is bits 8n+7:8n. With `cfg_lane_high_first`=1, it occupies lane L-1-n, where L is the number of bytes in a word.
- R5: In 8-bit mode, `cfg_lane_high_first` has no effect, and the byte always sits on bits 7:0.
- R6: A bit accepted with `in_last` high ends the frame. A partial byte is completed with zero bits, and then zero bytes are added up to the word boundary. The resulting word is emitted. If the final bit exactly completes a word, no extra word follows.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R8: When the output holds an unaccepted word and the next bit would complete a further word, `in_ready` is low. `in_ready` is also low while a frame-end word waits for the output.
- R9: The configuration inputs are sampled only while no bits are held and no frame-end word is waiting. A change made in the middle of a word alters neither that word nor the words that follow it until the block is empty again.
- R10: A high `clr` at a clock edge drops any held bits and any pending output word. `out_valid` is low after that edge, and the next bit starts a fresh word.
- R11: After reset, `out_valid` is low, `in_ready` is high and `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of held bits and the pending output word |
| cfg_width | input | 2 | Bus width code: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| cfg_bit_lsb_first | input | 1 | 0: earliest bit to the lane MSB; 1: earliest bit to the lane LSB |
| cfg_lane_high_first | input | 1 | 0: first byte in the lowest lane; 1: first byte in the highest lane |
| in_bit | input | 1 | Coded bit |
| in_valid | input | 1 | `in_bit` is valid |
| in_last | input | 1 | The current bit is the last bit of the frame |
| in_ready | output | 1 | The block accepts `in_bit` this cycle |
| out_word | output | 32 | Packed code word |
| out_valid | output | 1 | `out_word` holds a word |
| out_ready | input | 1 | The host takes `out_word` this cycle |
| cfg_err | output | 1 | The sampled width code is illegal |

## Verification
A wrong bit or lane index appears as a wrong value in the very first word emitted after the faulty bit, one cycle after the word fills. A wrong byte or word counter appears either as a word emitted too early or too late, or as a missing or surplus padded word at frame end.

Faults in configuration capture appear only when a configuration change arrives in the middle of a word. Faults in stall handling appear only when `out_ready` is held low. In that case a lost or overwritten word shows as a changed `out_word` on the next cycle, or as a word count that differs at frame end.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

  typedef enum logic [1:0] {
    BW_8   = 2'b00,
    BW_16  = 2'b01,
    BW_32  = 2'b10,
    BW_BAD = 2'b11
  } bus_w_e;

  typedef struct packed {
    bus_w_e width;
    logic   bit_lsb_first;
    logic   lane_high_first;
  } cbw_cfg_t;

endpackage

// File: rtl/cbw_rst_sync.sv
module cbw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cbw_bit_place.sv
// Maps (byte index, bit index) of the next arriving bit to its output bit position.
module cbw_bit_place #(
  parameter  int BYTE_W    = 8,
  parameter  int MAX_LANES = 4,
  localparam int BIT_CW    = $clog2(BYTE_W),
  localparam int LANE_CW   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int POS_W     = $clog2(BYTE_W * MAX_LANES)
) (
  input  logic [LANE_CW-1:0] byte_idx,
  input  logic [BIT_CW-1:0]  bit_idx,
  input  logic [LANE_CW-1:0] lanes_m1,
  input  logic               bit_lsb_first,
  input  logic               lane_high_first,
  output logic [POS_W-1:0]   pos
);

  logic [LANE_CW-1:0] lane_idx;
  logic [BIT_CW-1:0]  bit_in_lane;

  always_comb begin
    // lanes_m1 is zero in one-lane mode, so lane order has no effect there.
    lane_idx    = lane_high_first ? (lanes_m1 - byte_idx) : byte_idx;
    bit_in_lane = bit_lsb_first ? bit_idx : (BIT_CW'(BYTE_W - 1) - bit_idx);
    pos         = POS_W'(lane_idx) * POS_W'(BYTE_W) + POS_W'(bit_in_lane);
  end

endmodule

// File: rtl/cbw_accum.sv
// Holds the word being filled, its bit and byte counters and the frame-end flag.
module cbw_accum #(
  parameter  int BYTE_W    = 8,
  parameter  int MAX_LANES = 4,
  localparam int WORD_W    = BYTE_W * MAX_LANES,
  localparam int BIT_CW    = $clog2(BYTE_W),
  localparam int LANE_CW   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int POS_W     = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               take,
  input  logic               bit_i,
  input  logic               last_i,
  input  logic [LANE_CW-1:0] lanes_m1,
  input  logic [POS_W-1:0]   pos,
  input  logic               out_free,
  output logic               push,
  output logic [WORD_W-1:0]  push_word,
  output logic               pend,
  output logic               idle,
  output logic               near_full,
  output logic [LANE_CW-1:0] byte_idx,
  output logic [BIT_CW-1:0]  bit_idx
);

  logic [WORD_W-1:0]  acc_q, acc_d;
  logic [BIT_CW-1:0]  bit_q, bit_d;
  logic [LANE_CW-1:0] byte_q, byte_d;
  logic               pend_q, pend_d;
  logic [WORD_W-1:0]  hit;
  logic [WORD_W-1:0]  acc_plus;
  logic               push_full;
  logic               push_flush;

  // One decoder slice per output bit.
  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_hit
    assign hit[gi] = take && bit_i && (pos == POS_W'(gi));
  end

  always_comb begin
    near_full  = (bit_q == BIT_CW'(BYTE_W - 1)) && (byte_q == lanes_m1);
    acc_plus   = acc_q | hit;
    push_full  = take && near_full;
    push_flush = pend_q && out_free;
    push       = push_full || push_flush;
    push_word  = acc_plus;
    pend       = pend_q;
    idle       = (bit_q == '0) && (byte_q == '0) && !pend_q;
    byte_idx   = byte_q;
    bit_idx    = bit_q;
  end

  always_comb begin
    acc_d  = acc_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    pend_d = pend_q;
    if (clr || push) begin
      acc_d  = '0;
      bit_d  = '0;
      byte_d = '0;
      pend_d = 1'b0;
    end else if (take) begin
      acc_d  = acc_plus;
      pend_d = last_i;
      if (bit_q == BIT_CW'(BYTE_W - 1)) begin
        bit_d  = '0;
        byte_d = byte_q + 1'b1;
      end else begin
        bit_d  = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      pend_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/cbw_out_reg.sv
// Output holding register with a valid/ready handshake.
module cbw_out_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_free
);

  logic              valid_q, valid_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;

  always_comb begin
    out_free = !valid_q || out_ready;
    word_en  = push && !clr;
    valid_d  = valid_q;
    if (clr)            valid_d = 1'b0;
    else if (push)      valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= push_word;
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;

endmodule

// File: rtl/cbw_packer.sv
module cbw_packer #(
  parameter int BYTE_W    = 8,
  parameter int MAX_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic [1:0]                  cfg_width,
  input  logic                        cfg_bit_lsb_first,
  input  logic                        cfg_lane_high_first,
  input  logic                        in_bit,
  input  logic                        in_valid,
  input  logic                        in_last,
  output logic                        in_ready,
  output logic [BYTE_W*MAX_LANES-1:0] out_word,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        cfg_err
);
  import cbw_pkg::*;

  localparam int WORD_W  = BYTE_W * MAX_LANES;
  localparam int BIT_CW  = $clog2(BYTE_W);
  localparam int LANE_CW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;
  localparam int POS_W   = $clog2(WORD_W);

  logic               rst_sync_n;
  cbw_cfg_t           cfg_q, cfg_d;
  logic               idle;
  logic               pend;
  logic               near_full;
  logic               out_free;
  logic               push;
  logic [WORD_W-1:0]  push_word;
  logic               take;
  logic [LANE_CW-1:0] lanes_m1;
  logic [LANE_CW-1:0] byte_idx;
  logic [BIT_CW-1:0]  bit_idx;
  logic [POS_W-1:0]   pos;
  logic               width_bad;

  cbw_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_sync_n)
  );

  // Configuration capture: only while nothing is held.
  always_comb begin
    cfg_d = cfg_q;
    if (idle) begin
      cfg_d.width           = bus_w_e'(cfg_width);
      cfg_d.bit_lsb_first   = cfg_bit_lsb_first;
      cfg_d.lane_high_first = cfg_lane_high_first;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '{width: BW_8, bit_lsb_first: 1'b0, lane_high_first: 1'b0};
    else             cfg_q <= cfg_d;
  end

  always_comb begin
    width_bad = (cfg_q.width == BW_BAD) || ((32'd1 << cfg_q.width) > 32'(MAX_LANES));
    lanes_m1  = LANE_CW'((32'd1 << cfg_q.width) - 32'd1);
    cfg_err   = width_bad;
    in_ready  = width_bad || (!pend && (out_free || !near_full));
    take      = in_valid && in_ready && !width_bad;
  end

  cbw_bit_place #(.BYTE_W(BYTE_W), .MAX_LANES(MAX_LANES)) u_place (
    .byte_idx       (byte_idx),
    .bit_idx        (bit_idx),
    .lanes_m1       (lanes_m1),
    .bit_lsb_first  (cfg_q.bit_lsb_first),
    .lane_high_first(cfg_q.lane_high_first),
    .pos            (pos)
  );

  cbw_accum #(.BYTE_W(BYTE_W), .MAX_LANES(MAX_LANES)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .take     (take),
    .bit_i    (in_bit),
    .last_i   (in_last),
    .lanes_m1 (lanes_m1),
    .pos      (pos),
    .out_free (out_free),
    .push     (push),
    .push_word(push_word),
    .pend     (pend),
    .idle     (idle),
    .near_full(near_full),
    .byte_idx (byte_idx),
    .bit_idx  (bit_idx)
  );

  cbw_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .push     (push),
    .push_word(push_word),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_word (out_word),
    .out_free (out_free)
  );

endmodule

// File: rtl/cbw_packer_chk.sv
module cbw_packer_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              cfg_err,
  input logic              idle,
  input logic [3:0]        cfg_bits
);

  // R7: a stalled word stays put.
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_word)));

  // R2: with an illegal width nothing starts to come out.
  p_silent_on_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !out_valid) |=> !out_valid);

  // R9: configuration is frozen while bits are held.
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cfg_bits));

  // R10: clear drops the pending output.
  p_clr_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);

endmodule

bind cbw_packer cbw_packer_chk #(.WORD_W(BYTE_W * MAX_LANES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .clr      (clr),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_word (out_word),
  .cfg_err  (cfg_err),
  .idle     (idle),
  .cfg_bits (cfg_q)
);

// File: tb/cbw_packer_tb_top.sv
module cbw_packer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic [1:0]  cfg_width;
  logic        cfg_bit_lsb_first;
  logic        cfg_lane_high_first;
  logic        in_bit;
  logic        in_valid;
  logic        in_last;
  logic        in_ready;
  logic [31:0] out_word;
  logic        out_valid;
  logic        out_ready;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;

  logic        frame_bits [0:63];
  logic [31:0] exp_w [0:15];

  cbw_packer dut_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .clr                (clr),
    .cfg_width          (cfg_width),
    .cfg_bit_lsb_first  (cfg_bit_lsb_first),
    .cfg_lane_high_first(cfg_lane_high_first),
    .in_bit             (in_bit),
    .in_valid           (in_valid),
    .in_last            (in_last),
    .in_ready           (in_ready),
    .out_word           (out_word),
    .out_valid          (out_valid),
    .out_ready          (out_ready),
    .cfg_err            (cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  // Drives one frame of n bits and compares every emitted word with a computed one.
  task automatic run_frame(input int w, input int br, input int bs, input int n,
                           input int seed, input int rmode, input int scramble);
    int lanes, wb, n_exp, sent, got, cyc;
    logic        held_v;
    logic [31:0] held_w;
    string tag;
    cfg_width           = 2'(w);
    cfg_bit_lsb_first   = br[0];
    cfg_lane_high_first = bs[0];
    out_ready           = 1'b1;
    idle_cycles(3);
    lanes = 1 << w;
    wb    = 8 * lanes;
    n_exp = (n + wb - 1) / wb;
    for (int j = 0; j < 16; j++) exp_w[j] = '0;
    for (int k = 0; k < n; k++) begin
      int kk, by, bi, ln, p;
      frame_bits[k] = (((k * k + 3 * k + seed) % 7) > 2);
      kk = k % wb;
      by = kk / 8;
      bi = kk % 8;
      ln = (bs != 0 && lanes > 1) ? (lanes - 1 - by) : by;
      p  = ln * 8 + ((br != 0) ? bi : (7 - bi));
      if (frame_bits[k]) exp_w[k / wb][p] = 1'b1;
    end
    tag = (w == 0 && bs != 0) ? "R5 R1 R3 R6" :
          (scramble != 0)     ? "R9 R4 R3"    : "R1 R3 R4 R6";
    sent = 0; got = 0; cyc = 0; held_v = 1'b0; held_w = '0;
    while ((sent < n || got < n_exp) && cyc < 400) begin
      @(negedge clk);
      out_ready = (rmode != 0) ? ((cyc % 3) != 1) : 1'b1;
      if (sent < n) begin
        in_valid = 1'b1;
        in_bit   = frame_bits[sent];
        in_last  = (sent == n - 1);
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      if (scramble != 0 && sent == 3) begin
        cfg_width         = (w == 2) ? 2'b00 : 2'b10;
        cfg_bit_lsb_first = ~br[0];
      end
      #1;
      if (held_v) chk(out_valid && out_word == held_w, "R7 stall hold", out_word, held_w);
      held_v = out_valid && !out_ready;
      held_w = out_word;
      if (out_valid && out_ready) begin
        if (got < n_exp) chk(out_word == exp_w[got], tag, out_word, exp_w[got]);
        else             chk(1'b0, "R6 surplus word", out_word, 32'h0);
        got++;
      end
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    out_ready = 1'b1;
    chk(got == n_exp && sent == n, "R6 word count", 32'(got), 32'(n_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acc_cnt;
    logic ok_flag;
    rst_n = 1'b0; clr = 1'b0;
    cfg_width = 2'b00; cfg_bit_lsb_first = 1'b0; cfg_lane_high_first = 1'b0;
    in_bit = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(4);
    #1;
    // R11 reset state
    chk(!out_valid, "R11 out_valid", 32'(out_valid), 32'h0);
    chk(in_ready,   "R11 in_ready",  32'(in_ready),  32'h1);
    chk(!cfg_err,   "R11 cfg_err",   32'(cfg_err),   32'h0);

    // Sweep: width, bit order, lane order, length, output stall pattern.
    for (int w = 0; w < 3; w++)
      for (int br = 0; br < 2; br++)
        for (int bs = 0; bs < 2; bs++)
          for (int li = 0; li < 11; li++)
            for (int rm = 0; rm < 2; rm++) begin
              int lens [0:10] = '{1, 7, 8, 9, 16, 17, 24, 31, 32, 33, 40};
              run_frame(w, br, bs, lens[li], li * 5 + w + br * 3 + bs, rm, 0);
            end

    // R9: configuration changed in the middle of a 32-bit word.
    run_frame(2, 0, 1, 20, 9, 0, 1);
    run_frame(2, 1, 0, 32, 4, 1, 1);

    // R8: output stalled, next word full -> input blocked.
    cfg_width = 2'b00; cfg_bit_lsb_first = 1'b0; cfg_lane_high_first = 1'b0;
    idle_cycles(3);
    acc_cnt = 0;
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b0;
      #1;
      if (in_ready) acc_cnt++;
    end
    chk(acc_cnt == 15, "R8 bits accepted while stalled", 32'(acc_cnt), 32'd15);
    chk(!in_ready, "R8 in_ready", 32'(in_ready), 32'h0);
    chk(out_valid && out_word == 32'h0000_00FF, "R8 held word", out_word, 32'h0000_00FF);

    // R10: clear with a pending word and held bits.
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    #1;
    chk(!out_valid, "R10 out_valid after clr", 32'(out_valid), 32'h0);
    chk(in_ready,   "R10 in_ready after clr",  32'(in_ready),  32'h1);
    out_ready = 1'b1;
    run_frame(0, 0, 0, 8, 2, 0, 0);
    run_frame(1, 1, 1, 12, 7, 1, 0);

    // R2: reserved width code.
    cfg_width = 2'b11;
    idle_cycles(3);
    #1;
    chk(cfg_err, "R2 cfg_err", 32'(cfg_err), 32'h1);
    ok_flag = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = c[0]; in_last = (c == 39);
      #1;
      if (!in_ready || out_valid) ok_flag = 1'b0;
    end
    idle_cycles(3);
    #1;
    if (out_valid) ok_flag = 1'b0;
    chk(ok_flag, "R2 no output, bits consumed", 32'(ok_flag), 32'h1);
    cfg_width = 2'b00;
    idle_cycles(3);
    #1;
    chk(!cfg_err, "R2 cfg_err cleared", 32'(cfg_err), 32'h0);
    run_frame(0, 1, 0, 8, 11, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule